// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply and divide unit of a small scalar core. It owns the two architectural result registers, HI and LO, and takes commands over a single valid/ready port: a 6-bit function code plus two 32-bit operands. Four codes start a multi-cycle multiply or divide. Four codes move a value between a core register and HI or LO. The unit decodes the function codes itself. Any other code is accepted and has no effect.

Multiply and divide share one iterative datapath. It works on operand magnitudes: one set-up cycle, then 32 shift-add or restoring-subtract steps, then a final cycle that applies the signs and commits the result. A divide by zero does not raise an error. It writes zero to both HI and LO.

Back-pressure is only on the command side. A command is taken on a rising clock edge when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole time the datapath is busy, so a read of HI or LO that arrives during an operation waits until the new result has been committed. While the command waits, the driver must hold `cmd_valid` and the command fields steady. The read result port has no ready signal, because the register-file write port that receives it always accepts. `rd_valid` is a one-cycle pulse.

Top module: `mdu_hilo`

## Requirements
- R1: After reset, HI and LO read as 0, `busy`, `done` and `rd_valid` are low, and `cmd_ready` is high.
- R2: Function code 0x18 forms the signed 64-bit product of the two operands as two's-complement numbers. Product bits 31:0 go to LO and bits 63:32 go to HI.
- R3: Function code 0x19 forms the unsigned 64-bit product, with the same split: bits 31:0 to LO, bits 63:32 to HI.
- R4: Function code 0x1a is a signed divide. The quotient goes to LO and is truncated toward zero. The remainder goes to HI and takes the sign of the dividend. The case 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R5: Function code 0x1b is an unsigned divide, with the quotient in LO and the remainder in HI.
- R6: A divide (0x1a or 0x1b) whose divisor operand is zero sets both HI and LO to 0.
- R7: After a multiply or divide is accepted, `busy` is high for exactly 34 cycles. `done` pulses for one cycle in the cycle after `busy` falls, and the new HI/LO are visible from that cycle. HI and LO do not change while `busy` is high.
- R8: Function code 0x10 (read HI) or 0x12 (read LO) raises `rd_valid` for one cycle in the cycle after acceptance. `rd_data` then carries the value HI or LO held at acceptance. `rd_valid` is never high in any other case.
- R9: Function code 0x11 (write HI) or 0x13 (write LO) copies operand `cmd_a` into HI or LO. The new value is readable by the next command.
- R10: `cmd_ready` is low while `busy` is high. A read of HI or LO presented during an operation is stalled, with no `rd_valid`, and then returns the newly committed value.
- R11: Any function code other than 0x10–0x13 and 0x18–0x1b is accepted but does not change HI or LO, does not start `busy`, and does not raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_func | input | 6 | Function code |
| cmd_a | input | W | First operand (dividend, multiplicand, move source) |
| cmd_b | input | W | Second operand (divisor, multiplier) |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a HI/LO read |
| rd_data | output | W | Value read from HI or LO |
| busy | output | 1 | Multiply/divide in progress |
| done | output | 1 | One-cycle pulse: new HI/LO committed |

## Verification
The bench builds the unit with its default width W = 32, the width the function codes are defined for. At this width the 32-step iteration count and the 34-cycle busy window can be checked exactly. It also brings the 32-bit corners within reach: the most negative value squared, an all-ones unsigned product, the most negative value divided by minus one, and both divides by zero. Stalled reads and ignored function codes are observed only through `rd_valid`, `rd_data` and later reads of HI and LO.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int FUNC_W = 6;

  localparam logic [FUNC_W-1:0] F_RDHI = 6'h10;
  localparam logic [FUNC_W-1:0] F_WRHI = 6'h11;
  localparam logic [FUNC_W-1:0] F_RDLO = 6'h12;
  localparam logic [FUNC_W-1:0] F_WRLO = 6'h13;
  localparam logic [FUNC_W-1:0] F_MULS = 6'h18;
  localparam logic [FUNC_W-1:0] F_MULU = 6'h19;
  localparam logic [FUNC_W-1:0] F_DIVS = 6'h1a;
  localparam logic [FUNC_W-1:0] F_DIVU = 6'h1b;

  typedef enum logic [3:0] {
    K_NONE, K_MULS, K_MULU, K_DIVS, K_DIVU, K_RDHI, K_WRHI, K_RDLO, K_WRLO
  } kind_e;

  typedef struct packed {
    logic is_div;
    logic is_signed;
  } op_t;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RUN, S_FIN} eng_state_e;
endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
  import mdu_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output kind_e             kind,
  output logic              arith,
  output op_t               op
);
  always_comb begin
    unique case (func)
      F_MULS:  kind = K_MULS;
      F_MULU:  kind = K_MULU;
      F_DIVS:  kind = K_DIVS;
      F_DIVU:  kind = K_DIVU;
      F_RDHI:  kind = K_RDHI;
      F_WRHI:  kind = K_WRHI;
      F_RDLO:  kind = K_RDLO;
      F_WRLO:  kind = K_WRLO;
      default: kind = K_NONE;
    endcase
  end

  assign arith        = (kind == K_MULS) || (kind == K_MULU) ||
                        (kind == K_DIVS) || (kind == K_DIVU);
  assign op.is_div    = (kind == K_DIVS) || (kind == K_DIVU);
  assign op.is_signed = (kind == K_MULS) || (kind == K_DIVS);
endmodule

// File: rtl/mdu_engine.sv
module mdu_engine
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  op_t          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         fin_valid,
  output logic [W-1:0] fin_hi,
  output logic [W-1:0] fin_lo
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  eng_state_e    state;
  logic [CW-1:0] cnt;
  op_t           op_q;
  logic [W-1:0]  a_q, b_q, b_mag, acc_hi, acc_lo;
  logic          neg_lo, neg_hi, b_zero;

  // magnitudes of the latched operands
  logic [W-1:0] a_mag_c, b_mag_c;
  assign a_mag_c = (op_q.is_signed && a_q[W-1]) ? (~a_q + W'(1)) : a_q;
  assign b_mag_c = (op_q.is_signed && b_q[W-1]) ? (~b_q + W'(1)) : b_q;

  // one iteration step
  logic [W:0]   mul_sum, div_shl, div_diff;
  logic         div_ge;
  logic [W-1:0] nxt_hi, nxt_lo;
  always_comb begin
    mul_sum  = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, b_mag} : '0);
    div_shl  = {acc_hi, acc_lo[W-1]};
    div_diff = div_shl - {1'b0, b_mag};
    div_ge   = ~div_diff[W];
    if (op_q.is_div) begin
      nxt_hi = div_ge ? div_diff[W-1:0] : div_shl[W-1:0];
      nxt_lo = {acc_lo[W-2:0], div_ge};
    end else begin
      nxt_hi = mul_sum[W:1];
      nxt_lo = {mul_sum[0], acc_lo[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      b_mag  <= '0;
      acc_hi <= '0;
      acc_lo <= '0;
      neg_lo <= 1'b0;
      neg_hi <= 1'b0;
      b_zero <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          op_q  <= op;
          a_q   <= a;
          b_q   <= b;
          state <= S_SETUP;
        end
        S_SETUP: begin
          b_mag  <= b_mag_c;
          acc_hi <= '0;
          acc_lo <= a_mag_c;
          neg_lo <= op_q.is_signed & (a_q[W-1] ^ b_q[W-1]);
          neg_hi <= op_q.is_signed & a_q[W-1];
          b_zero <= (b_q == '0);
          cnt    <= '0;
          state  <= S_RUN;
        end
        S_RUN: begin
          acc_hi <= nxt_hi;
          acc_lo <= nxt_lo;
          cnt    <= cnt + CW'(1);
          if (cnt == LAST) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // final cycle: sign correction and result selection
  logic [2*W-1:0] prod;
  always_comb begin
    prod = {acc_hi, acc_lo};
    if (neg_lo) prod = ~prod + (2*W)'(1);
    if (!op_q.is_div) begin
      fin_hi = prod[2*W-1:W];
      fin_lo = prod[W-1:0];
    end else if (b_zero) begin
      fin_hi = '0;
      fin_lo = '0;
    end else begin
      fin_hi = neg_hi ? (~acc_hi + W'(1)) : acc_hi;
      fin_lo = neg_lo ? (~acc_lo + W'(1)) : acc_lo;
    end
  end

  assign busy      = (state != S_IDLE);
  assign fin_valid = (state == S_FIN);
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [W-1:0]      cmd_a,
  input  logic [W-1:0]      cmd_b,
  output logic              rd_valid,
  output logic [W-1:0]      rd_data,
  output logic              busy,
  output logic              done
);
  kind_e        kind;
  logic         arith, accept, eng_busy, fin_valid;
  op_t          op;
  logic [W-1:0] fin_hi, fin_lo;
  logic [W-1:0] hi_q, lo_q;

  mdu_decode u_dec (
    .func (cmd_func),
    .kind (kind),
    .arith(arith),
    .op   (op)
  );

  assign cmd_ready = ~eng_busy;
  assign accept    = cmd_valid & cmd_ready;

  mdu_engine #(.W(W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept & arith),
    .op       (op),
    .a        (cmd_a),
    .b        (cmd_b),
    .busy     (eng_busy),
    .fin_valid(fin_valid),
    .fin_hi   (fin_hi),
    .fin_lo   (fin_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q     <= '0;
      lo_q     <= '0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done     <= fin_valid;
      rd_valid <= accept & ((kind == K_RDHI) || (kind == K_RDLO));
      if (fin_valid) begin
        hi_q <= fin_hi;
        lo_q <= fin_lo;
      end else if (accept) begin
        if (kind == K_WRHI) hi_q <= cmd_a;
        if (kind == K_WRLO) lo_q <= cmd_a;
      end
      if (accept && kind == K_RDHI) rd_data <= hi_q;
      if (accept && kind == K_RDLO) rd_data <= lo_q;
    end
  end

  assign busy = eng_busy;
endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [5:0]   cmd_func,
  input logic         rd_valid,
  input logic [W-1:0] rd_data,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  a_r7_hilo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(hi_q) && $stable(lo_q)));

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_read_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_func == 6'h10) |=>
      (rd_valid && rd_data == $past(hi_q)));

  a_r8_read_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_func == 6'h12) |=>
      (rd_valid && rd_data == $past(lo_q)));

  a_r8_rd_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && cmd_ready));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> !rd_valid);
endmodule

bind mdu_hilo mdu_hilo_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_func (cmd_func),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .busy     (busy),
  .done     (done),
  .hi_q     (hi_q),
  .lo_q     (lo_q)
);

// File: tb/test_mdu_hilo.sv
module test_mdu_hilo;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [5:0]   cmd_func = '0;
  logic [W-1:0] cmd_a = '0, cmd_b = '0;
  logic         rd_valid;
  logic [W-1:0] rd_data;
  logic         busy, done;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdu_hilo #(.W(W)) i_mdu_hilo (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_func(cmd_func), .cmd_a(cmd_a), .cmd_b(cmd_b), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    cmd_valid = 1'b1; cmd_func = f; cmd_a = a; cmd_b = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [5:0] f, input string tag, output logic [W-1:0] val);
    issue(f, '0, '0);
    check({tag, " R8 rd_valid"}, W'(rd_valid), W'(1));
    val = rd_data;
    @(negedge clk);
    check({tag, " R8 rd_valid pulse"}, W'(rd_valid), W'(0));
  endtask

  function automatic void model(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] hi, output logic [W-1:0] lo);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    p = '0; q = 0; r = 0;
    case (f)
      6'h18: p = 64'(sa * sb);
      6'h19: p = {32'd0, a} * {32'd0, b};
      6'h1a: if (b != 0) begin q = sa / sb; r = sa % sb; p = {32'(r), 32'(q)}; end
      default: if (b != 0) p = {a % b, a / b};
    endcase
    hi = p[63:32];
    lo = p[31:0];
  endfunction

  task automatic t_reset;
    logic [W-1:0] v;
    check("R1 busy", W'(busy), W'(0));
    check("R1 cmd_ready", W'(cmd_ready), W'(1));
    check("R1 done", W'(done), W'(0));
    check("R1 rd_valid", W'(rd_valid), W'(0));
    read_reg(6'h10, "R1 HI", v); check("R1 HI zero", v, '0);
    read_reg(6'h12, "R1 LO", v); check("R1 LO zero", v, '0);
  endtask

  task automatic t_arith(input string tag, input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] eh, el, v;
    int n;
    model(f, a, b, eh, el);
    issue(f, a, b);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check({tag, " R7 busy cycles"}, W'(n), W'(34));
    check({tag, " R7 done"}, W'(done), W'(1));
    @(negedge clk);
    check({tag, " R7 done pulse"}, W'(done), W'(0));
    read_reg(6'h10, tag, v); check({tag, " HI"}, v, eh);
    read_reg(6'h12, tag, v); check({tag, " LO"}, v, el);
  endtask

  task automatic t_move;
    logic [W-1:0] v;
    issue(6'h11, 32'h1234_5678, 32'hFFFF_FFFF);
    check("R9 no rd_valid on write", W'(rd_valid), W'(0));
    issue(6'h13, 32'hCAFE_F00D, 32'h0);
    read_reg(6'h10, "R9 HI", v); check("R9 HI written", v, 32'h1234_5678);
    read_reg(6'h12, "R9 LO", v); check("R9 LO written", v, 32'hCAFE_F00D);
  endtask

  task automatic t_ignore;
    logic [W-1:0] v;
    issue(6'h20, 32'hDEAD_BEEF, 32'h1);
    check("R11 no busy", W'(busy), W'(0));
    check("R11 no rd_valid", W'(rd_valid), W'(0));
    issue(6'h1c, 32'h0BAD_0BAD, 32'h2);
    check("R11 no busy 1c", W'(busy), W'(0));
    read_reg(6'h10, "R11 HI", v); check("R11 HI unchanged", v, 32'h1234_5678);
    read_reg(6'h12, "R11 LO", v); check("R11 LO unchanged", v, 32'hCAFE_F00D);
  endtask

  task automatic t_stall;
    logic [W-1:0] eh, el;
    int n, early;
    model(6'h18, 32'hFFFF_FFF9, 32'd3, eh, el);
    issue(6'h18, 32'hFFFF_FFF9, 32'd3);
    cmd_valid = 1'b1; cmd_func = 6'h12; cmd_a = '0; cmd_b = '0;
    n = 0; early = 0;
    while (!cmd_ready) begin
      if (rd_valid) early++;
      n++;
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 stall cycles", W'(n), W'(34));
    check("R10 no early rd_valid", W'(early), W'(0));
    check("R10 rd_valid after stall", W'(rd_valid), W'(1));
    check("R10 stalled read gets new LO", rd_data, el);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith("R2 mul 5*-4", 6'h18, 32'd5, 32'hFFFF_FFFC);
    t_arith("R2 mul min*min", 6'h18, 32'h8000_0000, 32'h8000_0000);
    t_arith("R2 mul -7*3", 6'h18, 32'hFFFF_FFF9, 32'd3);
    t_arith("R3 mulu 5*fffffffc", 6'h19, 32'd5, 32'hFFFF_FFFC);
    t_arith("R3 mulu ones", 6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_arith("R4 div 7/-2", 6'h1a, 32'd7, 32'hFFFF_FFFE);
    t_arith("R4 div -7/2", 6'h1a, 32'hFFFF_FFF9, 32'd2);
    t_arith("R4 div min/-1", 6'h1a, 32'h8000_0000, 32'hFFFF_FFFF);
    t_arith("R5 divu", 6'h1b, 32'hFFFF_FFFF, 32'd10);
    t_arith("R5 divu small", 6'h1b, 32'd3, 32'd9);
    t_move();
    t_arith("R6 div by zero", 6'h1a, 32'h1234_5678, 32'd0);
    t_move();
    t_arith("R6 divu by zero", 6'h1b, 32'hFFFF_FFFF, 32'd0);
    t_move();
    t_ignore();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule